// File: doc/BRIEF.md
# Accumulator ALU with Borrow Subtract, Logic Operations and Mode-Timed Completion

This block is the execution stage for the byte operations of a small accumulator machine. When it is started it takes a left operand (the accumulator, or the memory byte for the form that writes back to memory), a second operand byte and the current condition flags. It then computes one of four operations: subtract with borrow, AND, OR or XOR. It returns the result byte, the new zero / auxiliary-carry / carry flags, and a select that says whether the result goes to the accumulator or to memory.

How long an instruction takes depends on where its second operand came from. The block models this timing. It stays busy for a number of clocks chosen by the addressing-mode code and then raises a one-clock done pulse, at which point the result and flags are valid. Operand fetch, memory writes and decoding happen elsewhere. This block only computes and times.

Subtraction writes all three flags. The three logical operations write only the zero flag and pass auxiliary carry and carry through unchanged. Unassigned operation or mode codes act as a four-clock operation that changes nothing.

Top module: `acc_alu8`

## Requirements
- R1: With op_i = 0 (subtract with borrow), result_o equals lhs_i − opnd_i − flags_i[0] modulo 256, and flags_o[0] (carry) is 1 exactly when that difference needs a borrow out of bit 7.
- R2: With op_i = 0, flags_o[1] (auxiliary carry) is 1 exactly when the low nibble lhs_i[3:0] − opnd_i[3:0] − flags_i[0] needs a borrow into bit 4.
- R3: With op_i = 1 (AND), 2 (OR) or 3 (XOR), result_o is the bitwise operation of lhs_i and opnd_i, and flags_o[1:0] equal flags_i[1:0].
- R4: For every valid operation and mode, flags_o[2] (zero) is 1 exactly when result_o is 0x00.
- R5: dest_mem_o is 1 when mode_i = 3 (short direct address with immediate) and the codes are valid, and 0 for every other mode.
- R6: done_o rises on the N-th rising edge, counting the edge that samples the accepted start as the first. N is 4 for modes 0 (immediate), 1 (register) and 2 (short direct). N is 6 for modes 3, 5 (HL indirect) and 6 (HL plus offset). N is 8 for mode 4 (16-bit absolute).
- R7: done_o is high for exactly one clock. result_o, flags_o and dest_mem_o change only on that clock and hold their values until the next completion.
- R8: busy_o is high from the edge that accepts a start until the edge that raises done_o. A start_i seen while busy_o is high is ignored and does not change the timing or the outcome of the operation in progress.
- R9: An op_i value of 4 to 7 or a mode_i value of 7 completes after 4 clocks with result_o = lhs_i, flags_o = flags_i and dest_mem_o = 0.
- R10: During and right after reset, done_o, busy_o, dest_mem_o, result_o and flags_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch strobe, sampled when not busy |
| op_i | input | 3 | Operation: 0 subtract-with-borrow, 1 AND, 2 OR, 3 XOR, 4–7 unassigned |
| mode_i | input | 3 | Addressing mode of the second operand, 0–6 valid, 7 unassigned |
| lhs_i | input | 8 | Left operand (accumulator, or memory byte in mode 3) |
| opnd_i | input | 8 | Second operand byte |
| flags_i | input | 3 | Incoming flags: bit 2 zero, bit 1 auxiliary carry, bit 0 carry |
| result_o | output | 8 | Result byte |
| dest_mem_o | output | 1 | 1 = result goes to memory, 0 = to accumulator |
| flags_o | output | 3 | Updated flags, same bit layout as flags_i |
| done_o | output | 1 | One-clock completion pulse |
| busy_o | output | 1 | Operation in progress |

## Verification
The subtract path is driven with patterns chosen to split the two borrow flags apart: a borrow only from the low nibble, borrows from both nibbles, a borrow that comes only from the incoming carry, and a wrap of 0x00 − 0xFF − 1 that gives zero together with both borrows. The logical operations are given incoming flags that differ from their expected outputs, so a path that recomputes auxiliary carry or carry instead of passing it through is caught. Each of the seven mode codes is covered at least once, which confirms both the latency class and the destination select. Unassigned codes, a start issued while busy, and output holding after done are tested separately.

// File: rtl/acc_alu8_pkg.sv
package acc_alu8_pkg;

   typedef enum logic [2:0] {
      OP_SUBB = 3'd0,
      OP_AND  = 3'd1,
      OP_OR   = 3'd2,
      OP_XOR  = 3'd3
   } alu_op_e;

   typedef enum logic [2:0] {
      MD_IMM     = 3'd0,
      MD_REG     = 3'd1,
      MD_SDIR    = 3'd2,
      MD_SDIR_IM = 3'd3,
      MD_ABS16   = 3'd4,
      MD_HLIND   = 3'd5,
      MD_HLOFS   = 3'd6
   } alu_mode_e;

   typedef struct packed {
      logic z;
      logic ac;
      logic cy;
   } alu_flags_t;

   localparam int OP_CODE_W   = 3;
   localparam int MODE_CODE_W = 3;

   function automatic logic op_is_valid(logic [OP_CODE_W-1:0] op);
      return op <= 3'd3;
   endfunction

   function automatic logic mode_is_valid(logic [MODE_CODE_W-1:0] md);
      return md <= 3'd6;
   endfunction

endpackage

// File: rtl/alu8_sub.sv
module alu8_sub #(
   parameter int DATA_W  = 8,
   parameter int AUX_BIT = 4,
   parameter bit RIPPLE  = 1'b1
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              bin_i,
   output logic [DATA_W-1:0] diff_o,
   output logic              aux_bo_o,
   output logic              bo_o
);

   generate
      if (RIPPLE) begin : g_ripple
         logic [DATA_W:0] brw;
         assign brw[0] = bin_i;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign diff_o[i]  = a_i[i] ^ b_i[i] ^ brw[i];
            assign brw[i+1]   = (~a_i[i] & b_i[i]) | (~(a_i[i] ^ b_i[i]) & brw[i]);
         end
         assign aux_bo_o = brw[AUX_BIT];
         assign bo_o     = brw[DATA_W];
      end else begin : g_native
         logic [DATA_W:0]  full;
         logic [AUX_BIT:0] low;
         assign full = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, bin_i};
         assign low  = {1'b0, a_i[AUX_BIT-1:0]} - {1'b0, b_i[AUX_BIT-1:0]}
                       - {{AUX_BIT{1'b0}}, bin_i};
         assign diff_o   = full[DATA_W-1:0];
         assign aux_bo_o = low[AUX_BIT];
         assign bo_o     = full[DATA_W];
      end
   endgenerate

endmodule

// File: rtl/alu8_exec.sv
module alu8_exec
   import acc_alu8_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int AUX_BIT = 4,
   parameter bit RIPPLE  = 1'b1
) (
   input  logic [OP_CODE_W-1:0] op_i,
   input  logic                 mode_ok_i,
   input  logic [DATA_W-1:0]    lhs_i,
   input  logic [DATA_W-1:0]    rhs_i,
   input  alu_flags_t           flg_i,
   output logic [DATA_W-1:0]    res_o,
   output alu_flags_t           flg_o
);

   logic [DATA_W-1:0] diff;
   logic              aux_bo;
   logic              bo;
   logic              live;

   alu8_sub #(
      .DATA_W (DATA_W),
      .AUX_BIT(AUX_BIT),
      .RIPPLE (RIPPLE)
   ) u_sub (
      .a_i     (lhs_i),
      .b_i     (rhs_i),
      .bin_i   (flg_i.cy),
      .diff_o  (diff),
      .aux_bo_o(aux_bo),
      .bo_o    (bo)
   );

   assign live = mode_ok_i && op_is_valid(op_i);

   always_comb begin
      res_o = lhs_i;
      flg_o = flg_i;
      if (live) begin
         unique case (alu_op_e'(op_i))
            OP_SUBB: begin
               res_o    = diff;
               flg_o.ac = aux_bo;
               flg_o.cy = bo;
            end
            OP_AND:  res_o = lhs_i & rhs_i;
            OP_OR:   res_o = lhs_i | rhs_i;
            OP_XOR:  res_o = lhs_i ^ rhs_i;
            default: res_o = lhs_i;
         endcase
         flg_o.z = (res_o == '0);
      end
   end

endmodule

// File: rtl/alu8_mode_decode.sv
module alu8_mode_decode
   import acc_alu8_pkg::*;
#(
   parameter int LAT_SHORT = 4,
   parameter int LAT_MID   = 6,
   parameter int LAT_LONG  = 8,
   parameter int CNT_W     = 4
) (
   input  logic [MODE_CODE_W-1:0] mode_i,
   input  logic [OP_CODE_W-1:0]   op_i,
   output logic                   mode_ok_o,
   output logic                   to_mem_o,
   output logic [CNT_W-1:0]       lat_o
);

   always_comb begin
      mode_ok_o = mode_is_valid(mode_i);
      to_mem_o  = 1'b0;
      lat_o     = CNT_W'(LAT_SHORT);
      if (mode_ok_o && op_is_valid(op_i)) begin
         unique case (alu_mode_e'(mode_i))
            MD_IMM, MD_REG, MD_SDIR: lat_o = CNT_W'(LAT_SHORT);
            MD_SDIR_IM: begin
               lat_o    = CNT_W'(LAT_MID);
               to_mem_o = 1'b1;
            end
            MD_HLIND, MD_HLOFS:      lat_o = CNT_W'(LAT_MID);
            MD_ABS16:                lat_o = CNT_W'(LAT_LONG);
            default:                 lat_o = CNT_W'(LAT_SHORT);
         endcase
      end
   end

endmodule

// File: rtl/alu8_timer.sv
module alu8_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             launch_i,
   input  logic [CNT_W-1:0] lat_i,
   output logic             busy_o,
   output logic             last_o,
   output logic             done_o
);

   logic [CNT_W-1:0] remain;

   assign last_o = busy_o && (remain == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_o <= 1'b0;
         done_o <= 1'b0;
         remain <= '0;
      end else begin
         done_o <= 1'b0;
         if (!busy_o) begin
            if (launch_i) begin
               busy_o <= 1'b1;
               remain <= lat_i - CNT_W'(2);
            end
         end else if (remain == '0) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
         end else begin
            remain <= remain - CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
   import acc_alu8_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int AUX_BIT   = 4,
   parameter int LAT_SHORT = 4,
   parameter int LAT_MID   = 6,
   parameter int LAT_LONG  = 8,
   parameter bit RIPPLE    = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [2:0]        op_i,
   input  logic [2:0]        mode_i,
   input  logic [DATA_W-1:0] lhs_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [2:0]        flags_i,
   output logic [DATA_W-1:0] result_o,
   output logic              dest_mem_o,
   output logic [2:0]        flags_o,
   output logic              done_o,
   output logic              busy_o
);

   localparam int CNT_W = $clog2(LAT_LONG + 1);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("acc_alu8: DATA_W must be at least 8");
      end
      if (AUX_BIT < 1 || AUX_BIT >= DATA_W) begin : g_bad_aux
         $error("acc_alu8: AUX_BIT out of range");
      end
      if (LAT_SHORT < 2 || LAT_MID < LAT_SHORT || LAT_LONG < LAT_MID) begin : g_bad_lat
         $error("acc_alu8: latencies must be ordered and at least 2");
      end
   endgenerate

   logic                 launch;
   logic                 last;
   logic                 mode_ok_d;
   logic                 to_mem_d;
   logic [CNT_W-1:0]     lat_d;
   logic [OP_CODE_W-1:0] op_q;
   logic                 mode_ok_q;
   logic                 to_mem_q;
   logic [DATA_W-1:0]    lhs_q;
   logic [DATA_W-1:0]    rhs_q;
   alu_flags_t           flg_q;
   logic [DATA_W-1:0]    res_d;
   alu_flags_t           flg_d;

   assign launch = start_i && !busy_o;

   alu8_mode_decode #(
      .LAT_SHORT(LAT_SHORT),
      .LAT_MID  (LAT_MID),
      .LAT_LONG (LAT_LONG),
      .CNT_W    (CNT_W)
   ) u_dec (
      .mode_i   (mode_i),
      .op_i     (op_i),
      .mode_ok_o(mode_ok_d),
      .to_mem_o (to_mem_d),
      .lat_o    (lat_d)
   );

   alu8_timer #(
      .CNT_W(CNT_W)
   ) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .launch_i(launch),
      .lat_i   (lat_d),
      .busy_o  (busy_o),
      .last_o  (last),
      .done_o  (done_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         op_q      <= '0;
         mode_ok_q <= 1'b0;
         to_mem_q  <= 1'b0;
         lhs_q     <= '0;
         rhs_q     <= '0;
         flg_q     <= '0;
      end else if (launch) begin
         op_q      <= op_i;
         mode_ok_q <= mode_ok_d;
         to_mem_q  <= to_mem_d;
         lhs_q     <= lhs_i;
         rhs_q     <= opnd_i;
         flg_q     <= alu_flags_t'(flags_i);
      end
   end

   alu8_exec #(
      .DATA_W (DATA_W),
      .AUX_BIT(AUX_BIT),
      .RIPPLE (RIPPLE)
   ) u_exec (
      .op_i     (op_q),
      .mode_ok_i(mode_ok_q),
      .lhs_i    (lhs_q),
      .rhs_i    (rhs_q),
      .flg_i    (flg_q),
      .res_o    (res_d),
      .flg_o    (flg_d)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         result_o   <= '0;
         dest_mem_o <= 1'b0;
         flags_o    <= '0;
      end else if (last) begin
         result_o   <= res_d;
         dest_mem_o <= to_mem_q;
         flags_o    <= flg_d;
      end
   end

endmodule

// File: rtl/acc_alu8_chk.sv
module acc_alu8_chk #(
   parameter int DATA_W    = 8,
   parameter int LAT_SHORT = 4,
   parameter int LAT_MID   = 6,
   parameter int LAT_LONG  = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              start_i,
   input logic [2:0]        op_i,
   input logic [2:0]        mode_i,
   input logic [DATA_W-1:0] lhs_i,
   input logic [DATA_W-1:0] opnd_i,
   input logic [2:0]        flags_i,
   input logic [DATA_W-1:0] result_o,
   input logic              dest_mem_o,
   input logic [2:0]        flags_o,
   input logic              done_o,
   input logic              busy_o
);

   logic [2:0]        op_c;
   logic [2:0]        mode_c;
   logic [DATA_W-1:0] lhs_c;
   logic [DATA_W-1:0] rhs_c;
   logic [2:0]        flg_c;
   logic [7:0]        ticks;
   logic [7:0]        want;
   logic              ok_c;
   logic [DATA_W:0]   ref_sub;

   assign ok_c    = (op_c <= 3'd3) && (mode_c <= 3'd6);
   assign ref_sub = {1'b0, lhs_c} - {1'b0, rhs_c} - {{DATA_W{1'b0}}, flg_c[0]};

   always_comb begin
      want = 8'(LAT_SHORT);
      if (ok_c) begin
         if (mode_c == 3'd4)                                        want = 8'(LAT_LONG);
         else if (mode_c == 3'd3 || mode_c == 3'd5 || mode_c == 3'd6) want = 8'(LAT_MID);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         op_c   <= '0;
         mode_c <= '0;
         lhs_c  <= '0;
         rhs_c  <= '0;
         flg_c  <= '0;
         ticks  <= '0;
      end else if (start_i && !busy_o) begin
         op_c   <= op_i;
         mode_c <= mode_i;
         lhs_c  <= lhs_i;
         rhs_c  <= opnd_i;
         flg_c  <= flags_i;
         ticks  <= 8'd1;
      end else if (busy_o) begin
         ticks  <= ticks + 8'd1;
      end
   end

   AST_SUB_DIFF_BORROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o && ok_c && op_c == 3'd0 |-> {flags_o[0], result_o} == ref_sub); // R1

   AST_LOGIC_KEEPS_AC_CY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o && ok_c && op_c != 3'd0 |-> flags_o[1:0] == flg_c[1:0]); // R3

   AST_ZERO_MATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o && ok_c |-> flags_o[2] == (result_o == '0)); // R4

   AST_DEST_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> dest_mem_o == (ok_c && mode_c == 3'd3)); // R5

   AST_MODE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> ticks == want); // R6

   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R7

   AST_HOLD_BETWEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> $stable(result_o) && $stable(flags_o) && $stable(dest_mem_o)); // R7

   AST_BUSY_BEFORE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o && $past(busy_o)); // R8

   AST_RESERVED_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o && !ok_c |-> result_o == lhs_c && flags_o == flg_c && !dest_mem_o); // R9

endmodule

bind acc_alu8 acc_alu8_chk #(
   .DATA_W   (DATA_W),
   .LAT_SHORT(LAT_SHORT),
   .LAT_MID  (LAT_MID),
   .LAT_LONG (LAT_LONG)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .start_i   (start_i),
   .op_i      (op_i),
   .mode_i    (mode_i),
   .lhs_i     (lhs_i),
   .opnd_i    (opnd_i),
   .flags_i   (flags_i),
   .result_o  (result_o),
   .dest_mem_o(dest_mem_o),
   .flags_o   (flags_o),
   .done_o    (done_o),
   .busy_o    (busy_o)
);

// File: tb/acc_alu8_tb_top.sv
module acc_alu8_tb_top;

   localparam int NVEC = 17;
   localparam int VW   = 41;

   // op, mode, lhs, opnd, flags in, result, flags out (Z AC CY), dest, latency
   localparam logic [VW-1:0] VEC [NVEC] = '{
      {3'd0, 3'd0, 8'h50, 8'h20, 3'b000, 8'h30, 3'b000, 1'b0, 4'd4},
      {3'd0, 3'd1, 8'h10, 8'h01, 3'b000, 8'h0F, 3'b010, 1'b0, 4'd4},
      {3'd0, 3'd2, 8'h00, 8'h01, 3'b000, 8'hFF, 3'b011, 1'b0, 4'd4},
      {3'd0, 3'd3, 8'h05, 8'h04, 3'b001, 8'h00, 3'b100, 1'b1, 4'd6},
      {3'd0, 3'd4, 8'h80, 8'h7F, 3'b001, 8'h00, 3'b110, 1'b0, 4'd8},
      {3'd0, 3'd5, 8'h34, 8'h34, 3'b001, 8'hFF, 3'b011, 1'b0, 4'd6},
      {3'd0, 3'd6, 8'hA5, 8'h3C, 3'b110, 8'h69, 3'b010, 1'b0, 4'd6},
      {3'd1, 3'd0, 8'hF0, 8'h0F, 3'b011, 8'h00, 3'b111, 1'b0, 4'd4},
      {3'd1, 3'd4, 8'hF3, 8'h3C, 3'b100, 8'h30, 3'b000, 1'b0, 4'd8},
      {3'd2, 3'd1, 8'h00, 8'h00, 3'b010, 8'h00, 3'b110, 1'b0, 4'd4},
      {3'd2, 3'd3, 8'h12, 8'h40, 3'b101, 8'h52, 3'b001, 1'b1, 4'd6},
      {3'd3, 3'd5, 8'hAA, 8'hAA, 3'b001, 8'h00, 3'b101, 1'b0, 4'd6},
      {3'd3, 3'd6, 8'h5A, 8'hFF, 3'b111, 8'hA5, 3'b011, 1'b0, 4'd6},
      {3'd3, 3'd2, 8'h0F, 8'hF0, 3'b010, 8'hFF, 3'b010, 1'b0, 4'd4},
      {3'd5, 3'd1, 8'h77, 8'h12, 3'b101, 8'h77, 3'b101, 1'b0, 4'd4},
      {3'd0, 3'd7, 8'h3C, 8'h01, 3'b010, 8'h3C, 3'b010, 1'b0, 4'd4},
      {3'd0, 3'd3, 8'h00, 8'hFF, 3'b001, 8'h00, 3'b111, 1'b1, 4'd6}
   };

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       start_i = 1'b0;
   logic [2:0] op_i = '0;
   logic [2:0] mode_i = '0;
   logic [7:0] lhs_i = '0;
   logic [7:0] opnd_i = '0;
   logic [2:0] flags_i = '0;
   logic [7:0] result_o;
   logic       dest_mem_o;
   logic [2:0] flags_o;
   logic       done_o;
   logic       busy_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2 clk_i = ~clk_i;

   acc_alu8 dut_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_i),
      .op_i      (op_i),
      .mode_i    (mode_i),
      .lhs_i     (lhs_i),
      .opnd_i    (opnd_i),
      .flags_i   (flags_i),
      .result_o  (result_o),
      .dest_mem_o(dest_mem_o),
      .flags_o   (flags_o),
      .done_o    (done_o),
      .busy_o    (busy_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic launch(input logic [2:0] op, input logic [2:0] md, input logic [7:0] a,
                         input logic [7:0] b, input logic [2:0] f);
      @(negedge clk_i);
      start_i = 1'b1;
      op_i = op; mode_i = md; lhs_i = a; opnd_i = b; flags_i = f;
      @(negedge clk_i);
      start_i = 1'b0;
   endtask

   // returns the edge count at which done was seen (edge that took start = 1)
   task automatic wait_done(output int edges);
      edges = 1;
      while (!done_o && edges < 40) begin
         @(negedge clk_i);
         edges++;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk_i);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int e;
      logic [7:0] held;
      repeat (3) @(negedge clk_i);
      // R10 reset state
      check(done_o == 0 && busy_o == 0 && dest_mem_o == 0, "R10 ctrl", {done_o, busy_o, dest_mem_o}, 0);
      check(result_o == 0 && flags_o == 0, "R10 data", {result_o, flags_o}, 0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      check(result_o == 0 && flags_o == 0 && !busy_o, "R10 after release", {result_o, flags_o}, 0);

      // vector table: R1 R2 R3 R4 R5 R6 R9
      for (int i = 0; i < NVEC; i++) begin
         logic [VW-1:0] v;
         v = VEC[i];
         launch(v[40:38], v[37:35], v[34:27], v[26:19], v[18:16]);
         check(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
         wait_done(e);
         check(e == int'(v[3:0]), "R6 latency", e, v[3:0]);
         check(result_o == v[15:8], (v[40:38] == 0 && v[37:35] != 7) ? "R1 result" :
               (v[40:38] > 3 || v[37:35] == 7) ? "R9 result" : "R3 result", result_o, v[15:8]);
         check(flags_o == v[7:5], (v[40:38] == 0) ? "R2 R4 flags" : "R3 R4 R9 flags", flags_o, v[7:5]);
         check(dest_mem_o == v[4], "R5 dest", dest_mem_o, v[4]);
         check(!busy_o, "R8 busy low at done", busy_o, 0);
         @(negedge clk_i);
         check(!done_o, "R7 done single pulse", done_o, 0);
      end

      // R7 outputs hold after completion
      held = result_o;
      repeat (5) @(negedge clk_i);
      check(result_o == held && flags_o == 3'b111 && dest_mem_o, "R7 hold", result_o, held);

      // R8 start while busy is ignored
      launch(3'd1, 3'd0, 8'hFF, 8'h0F, 3'b000);
      start_i = 1'b1; op_i = 3'd3; mode_i = 3'd4; lhs_i = 8'h00; opnd_i = 8'h00; flags_i = 3'b011;
      @(negedge clk_i);
      start_i = 1'b0;
      e = 2;
      while (!done_o && e < 40) begin
         @(negedge clk_i);
         e++;
      end
      check(e == 4, "R8 latency unchanged", e, 4);
      check(result_o == 8'h0F && flags_o == 3'b000, "R8 first op kept", {result_o, flags_o}, {8'h0F, 3'b000});
      e = 0;
      repeat (12) begin
         @(negedge clk_i);
         if (done_o) e++;
      end
      check(e == 0, "R8 no second completion", e, 0);

      // R10 reset while busy
      launch(3'd0, 3'd4, 8'h11, 8'h22, 3'b000);
      rst_ni = 1'b0;
      @(negedge clk_i);
      check(!busy_o && !done_o && result_o == 0 && flags_o == 0, "R10 reset mid-op",
            {busy_o, done_o, result_o, flags_o}, 0);
      rst_ni = 1'b1;
      repeat (10) @(negedge clk_i);
      check(!done_o && !busy_o, "R10 no stale done", {done_o, busy_o}, 0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule